// File: doc/BRIEF.md
# Class-D Amplifier Power-State and Configuration Controller

This block runs the power-state machine of a speaker amplifier that takes its audio and its commands over the same one-bit pulse-density stream. A recognizer upstream turns the stream into events: a strobe for each decoded control word with its code number, a strobe for each stretch of real audio data, a strobe for a stuck-bit error, and a level that says the bit clock has stopped. The controller counts how many times in a row the same code has arrived. It uses these counts to move between the off, standby and on states and to edit a small set of configuration registers.

Configuration is written only while the amplifier is in standby. It is written by sending a code repeatedly. Codes 3, 4 and 5 flip or set fields directly. Code 6 makes the next command use a second meaning, and that second meaning lasts for one command only. On the second page, bits of the slew-rate and performance fields are flipped, or a two-bit field is incremented. The driver enable is high only in the on state, and a protection fault forces it low without touching the state.

Top module: `pdmamp_power_ctrl`

## Requirements
- R1: Reset gives state off (`pwrState` encoding: 0 off, 1 standby, 2 on), `drvEn` low, slew field 01, `perfPc1` 1, `perfPc2` 01, `hpfEn` 1, `mode32k` 0 and `supply5v` 0.
- R2: While `clkStopped` is high, the state becomes off on the next edge. In off with `clkStopped` low, the state becomes standby on the next edge.
- R3: In standby the state becomes on after an `audioSeen` strobe, after the 4th consecutive code 1, after the 32nd consecutive code 9, or after the 32nd consecutive code 10 (code numbers as given on `codeId`). Code 10 sets `supply5v` to 1. Codes 1 and 9 clear it.
- R4: In on the state becomes standby after the 32nd consecutive code 2, after the 64th consecutive copy of any code, or after an `errEvent` strobe.
- R5: A run of one repeated code causes at most one state change. A run ends when an audio strobe arrives or a code with a different number arrives.
- R6: Configuration fields change only when a command completes while in standby. The same runs sent in on leave them unchanged.
- R7: The 32nd consecutive code 6 in standby selects the second page for the next completed command only. After that command, the first page applies again. Page-two meanings of codes 9 and 10 do not start the amplifier.
- R8: On the first page, 32 consecutive code 3 flips slew bit 1, code 4 sets `mode32k`, and code 5 clears `hpfEn`.
- R9: On the second page, 32 consecutive code 3 flips `perfPc1`, code 9 flips slew bit 0, and code 10 increments `perfPc2` modulo 4.
- R10: `hpfEn`, `mode32k`, the slew field and the performance fields return to their reset values only when the clock stops. They do not return on standby or on transitions.
- R11: A start caused by audio keeps the last supply selection. After reset or a clock stop, that selection is the 3.6 V mode (`supply5v` 0).
- R12: `drvEn` is high exactly when the state is on and `faultIn` is low. `faultIn` does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkStopped | input | 1 | Bit clock absent (level) |
| codeValid | input | 1 | One decoded control word (strobe) |
| codeId | input | 4 | Code number 1 to 10 of that word |
| audioSeen | input | 1 | Audio data detected (strobe) |
| errEvent | input | 1 | Stuck-bit error detected (strobe) |
| faultIn | input | 1 | Protection fault (level) |
| pwrState | output | 2 | 0 off, 1 standby, 2 on |
| drvEn | output | 1 | Speaker driver enable |
| slewSel | output | 2 | Output slew select, 00 to 11 for 5, 10, 20 and 40 ns |
| perfPc1 | output | 1 | Performance bit, 0 selects best SNR |
| perfPc2 | output | 2 | Performance field, 00 with `perfPc1` 1 gives best PSRR |
| hpfEn | output | 1 | Input high-pass filter enable |
| mode32k | output | 1 | 32 kHz sample-rate mode |
| supply5v | output | 1 | 5 V supply mode selected |

## Verification
The bench goes after the run boundaries first. A start code sent past 64 copies must not bounce the amplifier back to standby. A design that fires at every count above the threshold, instead of at the threshold only, would toggle states or flip bits on every word. Page two is checked to expire after exactly one command. If it expired too late, a following code 3 would flip the performance bit instead of the slew bit. If it did not apply at all, codes 9 and 10 would start the amplifier instead of editing fields. The bench also runs the same configuration runs while on, which must change nothing. It checks the `perfPc2` wrap from 11 to 00. Finally it checks that a supply selection made earlier is still there on an audio start, and that it falls back to 3.6 V after a clock stop.

// File: rtl/pdmamp_pkg.sv
package pdmamp_pkg;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_STBY = 2'd1,
    PS_ON   = 2'd2
  } pwr_state_e;

  // One-cycle commands from the state control to the register bank
  typedef struct packed {
    logic restore;    // clock gone: back to defaults
    logic invSlewHi;
    logic invSlewLo;
    logic set32k;
    logic hpfOff;
    logic invPc1;
    logic incPc2;
    logic selSup5;
    logic selSup36;
  } cfg_strobe_t;

endpackage

// File: rtl/pdmamp_ctrl.sv
module pdmamp_ctrl
  import pdmamp_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int FAST_RUN = 4,
  parameter int CMD_RUN  = 32,
  parameter int ANY_RUN  = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clkStopped,
  input  logic            codeValid,
  input  logic [ID_W-1:0] codeId,
  input  logic            audioSeen,
  input  logic            errEvent,
  output pwr_state_e      state,
  output cfg_strobe_t     strobe
);

  localparam int CNT_W = $clog2(ANY_RUN + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] FAST_LEN = CNT_W'(FAST_RUN);
  localparam logic [CNT_W-1:0] CMD_LEN  = CNT_W'(CMD_RUN);
  localparam logic [CNT_W-1:0] ANY_LEN  = CNT_W'(ANY_RUN);
  localparam logic [ID_W-1:0] C_FAST  = ID_W'(1);
  localparam logic [ID_W-1:0] C_SLEEP = ID_W'(2);
  localparam logic [ID_W-1:0] C_FLIP  = ID_W'(3);
  localparam logic [ID_W-1:0] C_RATE  = ID_W'(4);
  localparam logic [ID_W-1:0] C_HPF   = ID_W'(5);
  localparam logic [ID_W-1:0] C_PAGE  = ID_W'(6);
  localparam logic [ID_W-1:0] C_LOWV  = ID_W'(9);
  localparam logic [ID_W-1:0] C_HIGHV = ID_W'(10);

  pwr_state_e       stateNxt;
  logic [CNT_W-1:0] runCnt, cntNxt;
  logic [ID_W-1:0]  lastId, lastNxt;
  logic             moved, movedNxt;
  logic             pageTwo, pageNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = runCnt;
    lastNxt  = lastId;
    movedNxt = moved;
    pageNxt  = pageTwo;
    strobe   = '0;
    if (clkStopped) begin
      stateNxt       = PS_OFF;
      cntNxt         = '0;
      lastNxt        = '0;
      movedNxt       = 1'b0;
      pageNxt        = 1'b0;
      strobe.restore = 1'b1;
    end else if (state == PS_OFF) begin
      stateNxt = PS_STBY;
    end else if (errEvent) begin
      if (state == PS_ON) stateNxt = PS_STBY;
    end else if (audioSeen) begin
      cntNxt   = '0;
      lastNxt  = '0;
      movedNxt = 1'b0;
      if (state == PS_STBY) stateNxt = PS_ON;
    end else if (codeValid) begin
      if (codeId == lastId && runCnt != '0) begin
        cntNxt = (runCnt == CNT_MAX) ? runCnt : runCnt + 1'b1;
      end else begin
        cntNxt   = CNT_W'(1);
        lastNxt  = codeId;
        movedNxt = 1'b0;
      end
      if (state == PS_STBY && !movedNxt) begin
        if (pageTwo) begin
          if (cntNxt == CMD_LEN) begin
            pageNxt = 1'b0;
            case (codeId)
              C_FLIP:  strobe.invPc1    = 1'b1;
              C_LOWV:  strobe.invSlewLo = 1'b1;
              C_HIGHV: strobe.incPc2    = 1'b1;
              default: ;
            endcase
          end
        end else if (codeId == C_FAST && cntNxt == FAST_LEN) begin
          stateNxt        = PS_ON;
          movedNxt        = 1'b1;
          strobe.selSup36 = 1'b1;
        end else if (cntNxt == CMD_LEN) begin
          case (codeId)
            C_LOWV: begin
              stateNxt        = PS_ON;
              movedNxt        = 1'b1;
              strobe.selSup36 = 1'b1;
            end
            C_HIGHV: begin
              stateNxt       = PS_ON;
              movedNxt       = 1'b1;
              strobe.selSup5 = 1'b1;
            end
            C_FLIP:  strobe.invSlewHi = 1'b1;
            C_RATE:  strobe.set32k    = 1'b1;
            C_HPF:   strobe.hpfOff    = 1'b1;
            C_PAGE:  pageNxt          = 1'b1;
            default: ;
          endcase
        end
      end else if (state == PS_ON && !movedNxt) begin
        if ((codeId == C_SLEEP && cntNxt == CMD_LEN) || cntNxt == ANY_LEN) begin
          stateNxt = PS_STBY;
          movedNxt = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PS_OFF;
      runCnt  <= '0;
      lastId  <= '0;
      moved   <= 1'b0;
      pageTwo <= 1'b0;
    end else begin
      state   <= stateNxt;
      runCnt  <= cntNxt;
      lastId  <= lastNxt;
      moved   <= movedNxt;
      pageTwo <= pageNxt;
    end
  end

endmodule

// File: rtl/pdmamp_cfg.sv
module pdmamp_cfg
  import pdmamp_pkg::*;
#(
  parameter int SLEW_W = 2,
  parameter int PC2_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strobe,
  output logic [SLEW_W-1:0] slewSel,
  output logic              perfPc1,
  output logic [PC2_W-1:0]  perfPc2,
  output logic              hpfEn,
  output logic              mode32k,
  output logic              supply5v
);

  localparam logic [SLEW_W-1:0] SLEW_DEF = SLEW_W'(1);
  localparam logic [PC2_W-1:0]  PC2_DEF  = PC2_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slewSel  <= SLEW_DEF;
      perfPc1  <= 1'b1;
      perfPc2  <= PC2_DEF;
      hpfEn    <= 1'b1;
      mode32k  <= 1'b0;
      supply5v <= 1'b0;
    end else if (strobe.restore) begin
      slewSel  <= SLEW_DEF;
      perfPc1  <= 1'b1;
      perfPc2  <= PC2_DEF;
      hpfEn    <= 1'b1;
      mode32k  <= 1'b0;
      supply5v <= 1'b0;
    end else begin
      if (strobe.invSlewHi) slewSel[SLEW_W-1] <= ~slewSel[SLEW_W-1];
      if (strobe.invSlewLo) slewSel[0] <= ~slewSel[0];
      if (strobe.invPc1) perfPc1 <= ~perfPc1;
      if (strobe.incPc2) perfPc2 <= perfPc2 + 1'b1;
      if (strobe.hpfOff) hpfEn <= 1'b0;
      if (strobe.set32k) mode32k <= 1'b1;
      if (strobe.selSup5) supply5v <= 1'b1;
      else if (strobe.selSup36) supply5v <= 1'b0;
    end
  end

endmodule

// File: rtl/pdmamp_power_ctrl.sv
module pdmamp_power_ctrl
  import pdmamp_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int FAST_RUN = 4,
  parameter int CMD_RUN  = 32,
  parameter int ANY_RUN  = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clkStopped,
  input  logic            codeValid,
  input  logic [ID_W-1:0] codeId,
  input  logic            audioSeen,
  input  logic            errEvent,
  input  logic            faultIn,
  output logic [1:0]      pwrState,
  output logic            drvEn,
  output logic [1:0]      slewSel,
  output logic            perfPc1,
  output logic [1:0]      perfPc2,
  output logic            hpfEn,
  output logic            mode32k,
  output logic            supply5v
);

  pwr_state_e  state;
  cfg_strobe_t strobe;

  pdmamp_ctrl #(
    .ID_W(ID_W), .FAST_RUN(FAST_RUN), .CMD_RUN(CMD_RUN), .ANY_RUN(ANY_RUN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .clkStopped(clkStopped), .codeValid(codeValid),
    .codeId(codeId), .audioSeen(audioSeen), .errEvent(errEvent),
    .state(state), .strobe(strobe)
  );

  pdmamp_cfg #(.SLEW_W(2), .PC2_W(2)) i_cfg (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slewSel(slewSel),
    .perfPc1(perfPc1), .perfPc2(perfPc2), .hpfEn(hpfEn),
    .mode32k(mode32k), .supply5v(supply5v)
  );

  assign pwrState = state;
  assign drvEn    = (state == PS_ON) && !faultIn;

endmodule

// File: rtl/pdmamp_power_chk.sv
module pdmamp_power_chk (
  input logic       clk,
  input logic       rstN,
  input logic       clkStopped,
  input logic       faultIn,
  input logic [1:0] pwrState,
  input logic       drvEn,
  input logic [1:0] slewSel,
  input logic       perfPc1,
  input logic [1:0] perfPc2,
  input logic       hpfEn,
  input logic       mode32k
);

  p_to_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    clkStopped |=> pwrState == 2'd0);

  p_off_exit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && !clkStopped) |=> pwrState == 2'd1);

  p_no_direct_on_r3: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd0 |=> pwrState != 2'd2);

  p_cfg_frozen_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2 && !clkStopped) |=>
      ($stable(slewSel) && $stable(perfPc1) && $stable(perfPc2)
       && $stable(hpfEn) && $stable(mode32k)));

  p_hpf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!hpfEn && !clkStopped) |=> !hpfEn);

  p_rate_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode32k && !clkStopped) |=> mode32k);

  p_fault_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |-> !drvEn);

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    pwrState != 2'd3);

endmodule

bind pdmamp_power_ctrl pdmamp_power_chk i_chk (
  .clk(clk), .rstN(rstN), .clkStopped(clkStopped), .faultIn(faultIn),
  .pwrState(pwrState), .drvEn(drvEn), .slewSel(slewSel), .perfPc1(perfPc1),
  .perfPc2(perfPc2), .hpfEn(hpfEn), .mode32k(mode32k)
);

// File: tb/test_pdmamp_power_ctrl.sv
`timescale 1ns/1ps
module test_pdmamp_power_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkStopped = 1'b0;
  logic       codeValid = 1'b0;
  logic [3:0] codeId = '0;
  logic       audioSeen = 1'b0;
  logic       errEvent = 1'b0;
  logic       faultIn = 1'b0;
  logic [1:0] pwrState;
  logic       drvEn;
  logic [1:0] slewSel;
  logic       perfPc1;
  logic [1:0] perfPc2;
  logic       hpfEn;
  logic       mode32k;
  logic       supply5v;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pdmamp_power_ctrl i_pdmamp_power_ctrl (
    .clk(clk), .rstN(rstN), .clkStopped(clkStopped), .codeValid(codeValid),
    .codeId(codeId), .audioSeen(audioSeen), .errEvent(errEvent),
    .faultIn(faultIn), .pwrState(pwrState), .drvEn(drvEn), .slewSel(slewSel),
    .perfPc1(perfPc1), .perfPc2(perfPc2), .hpfEn(hpfEn), .mode32k(mode32k),
    .supply5v(supply5v)
  );

  // reference model state, built from the requirements
  int mState, mCnt, mLast, mSr, mPc1, mPc2, mHpf, m32, mSup;
  bit mMoved, mPage;

  task automatic modelDefaults();
    mSr = 1; mPc1 = 1; mPc2 = 1; mHpf = 1; m32 = 0; mSup = 0;
  endtask

  task automatic modelStep(bit cv, int id, bit au, bit er, bit cs);
    if (cs) begin
      mState = 0; mCnt = 0; mLast = 0; mMoved = 0; mPage = 0;
      modelDefaults();
    end else if (mState == 0) begin
      mState = 1;
    end else if (er) begin
      if (mState == 2) mState = 1;
    end else if (au) begin
      mCnt = 0; mLast = 0; mMoved = 0;
      if (mState == 1) mState = 2;
    end else if (cv) begin
      if (id == mLast && mCnt != 0) begin
        if (mCnt < 127) mCnt++;
      end else begin
        mCnt = 1; mLast = id; mMoved = 0;
      end
      if (mState == 1 && !mMoved) begin
        if (mPage) begin
          if (mCnt == 32) begin
            mPage = 0;
            if (id == 3) mPc1 ^= 1;
            if (id == 9) mSr ^= 1;
            if (id == 10) mPc2 = (mPc2 + 1) % 4;
          end
        end else if (id == 1 && mCnt == 4) begin
          mState = 2; mMoved = 1; mSup = 0;
        end else if (mCnt == 32) begin
          case (id)
            9: begin mState = 2; mMoved = 1; mSup = 0; end
            10: begin mState = 2; mMoved = 1; mSup = 1; end
            3: mSr ^= 2;
            4: m32 = 1;
            5: mHpf = 0;
            6: mPage = 1;
            default: ;
          endcase
        end
      end else if (mState == 2 && !mMoved) begin
        if ((id == 2 && mCnt == 32) || mCnt == 64) begin
          mState = 1; mMoved = 1;
        end
      end
    end
  endtask

  function automatic int packExp();
    int d = (mState == 2 && !faultIn) ? 1 : 0;
    return (mState << 9) | (d << 8) | (mSr << 6) | (mPc1 << 5) | (mPc2 << 3)
         | (mHpf << 2) | (m32 << 1) | mSup;
  endfunction

  function automatic int packAct();
    return {21'd0, pwrState, drvEn, slewSel, perfPc1, perfPc2, hpfEn, mode32k, supply5v};
  endfunction

  task automatic expectEq(int act, int exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic tick(bit cv, int id, bit au, bit er);
    codeValid = cv; codeId = 4'(id); audioSeen = au; errEvent = er;
    @(posedge clk);
    modelStep(cv, id, au, er, clkStopped);
    @(negedge clk);
    codeValid = 0; audioSeen = 0; errEvent = 0;
    expectEq(packAct(), packExp(), "R3 R4 R8 model compare");
  endtask

  task automatic sendRun(int id, int len);
    for (int i = 0; i < len; i++) tick(1, id, 0, 0);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    mState = 0; mCnt = 0; mLast = 0; mMoved = 0; mPage = 0;
    modelDefaults();
    repeat (3) @(negedge clk);
    // R1 reset values
    expectEq(pwrState, 0, "R1 state");
    expectEq(drvEn, 0, "R1 drvEn");
    expectEq(slewSel, 1, "R1 slew");
    expectEq(perfPc1, 1, "R1 pc1");
    expectEq(perfPc2, 1, "R1 pc2");
    expectEq({hpfEn, mode32k, supply5v}, 3'b100, "R1 hpf/32k/supply");
    rstN = 1;
    tick(0, 0, 0, 0);
    expectEq(pwrState, 1, "R2 off to standby");

    sendRun(3, 32); expectEq(slewSel, 3, "R8 code3 flips slew bit1");
    sendRun(4, 32); expectEq(mode32k, 1, "R8 code4 sets 32k");
    sendRun(5, 32); expectEq(hpfEn, 0, "R8 code5 clears hpf");
    sendRun(6, 32); sendRun(9, 32);
    expectEq(slewSel, 2, "R9 page2 code9 flips slew bit0");
    expectEq(pwrState, 1, "R7 page2 code9 does not start");
    sendRun(3, 32);
    expectEq(slewSel, 0, "R7 page back to 1 after one command");
    expectEq(perfPc1, 1, "R7 pc1 untouched on page1");
    for (int k = 0; k < 3; k++) begin sendRun(6, 32); sendRun(10, 32); end
    expectEq(perfPc2, 0, "R9 pc2 wraps 3 to 0");
    expectEq(pwrState, 1, "R7 page2 code10 does not start");
    sendRun(6, 32); sendRun(3, 32);
    expectEq(perfPc1, 0, "R9 page2 code3 flips pc1");
    sendRun(10, 32);
    expectEq(pwrState, 2, "R3 code10 start");
    expectEq(supply5v, 1, "R3 code10 selects 5V");
    sendRun(3, 32);
    expectEq(slewSel, 0, "R6 no config in on");
    sendRun(2, 32);
    expectEq(pwrState, 1, "R4 code2 standby");
    tick(0, 0, 1, 0);
    expectEq(pwrState, 2, "R3 audio start");
    expectEq(supply5v, 1, "R11 supply kept on audio start");
    tick(0, 0, 0, 1);
    expectEq(pwrState, 1, "R4 error to standby");
    sendRun(1, 3);
    expectEq(pwrState, 1, "R3 three code1 not enough");
    sendRun(1, 1);
    expectEq(pwrState, 2, "R3 fourth code1 starts");
    expectEq(supply5v, 0, "R3 code1 selects 3.6V");
    sendRun(1, 61);
    expectEq(pwrState, 2, "R5 one transition per run");
    sendRun(5, 1); sendRun(1, 64);
    expectEq(pwrState, 1, "R4 64 of any code");
    tick(0, 0, 1, 0);
    faultIn = 1; tick(0, 0, 0, 0);
    expectEq(drvEn, 0, "R12 fault gates driver");
    expectEq(pwrState, 2, "R12 fault keeps state");
    faultIn = 0; tick(0, 0, 0, 0);
    expectEq(drvEn, 1, "R12 driver back after fault");
    expectEq(hpfEn, 0, "R10 hpf held across transitions");
    clkStopped = 1; tick(0, 0, 0, 0);
    expectEq(pwrState, 0, "R2 clock stop gives off");
    expectEq(slewSel, 1, "R10 slew restored");
    expectEq({hpfEn, mode32k, perfPc1}, 3'b101, "R10 hpf/32k/pc1 restored");
    clkStopped = 0; tick(0, 0, 0, 0); tick(0, 0, 1, 0);
    expectEq(pwrState, 2, "R3 audio start after restore");
    expectEq(supply5v, 0, "R11 default 3.6V after clock stop");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int r = $urandom_range(0, 99);
      if (r < 55) begin
        int id = $urandom_range(1, 10);
        int len;
        case ($urandom_range(0, 5))
          0: len = 4;
          1: len = 32;
          2: len = 64;
          3: len = 31;
          4: len = 33;
          default: len = $urandom_range(1, 70);
        endcase
        sendRun(id, len);
      end else if (r < 70) tick(0, 0, 1, 0);
      else if (r < 77) tick(0, 0, 0, 1);
      else if (r < 85) repeat ($urandom_range(1, 4)) tick(0, 0, 0, 0);
      else if (r < 89) begin
        clkStopped = 1; tick(0, 0, 0, 0); tick(0, 0, 0, 0);
        clkStopped = 0; tick(0, 0, 0, 0);
      end else begin
        faultIn = ~faultIn; tick(0, 0, 0, 0);
      end
    end
    faultIn = 0;
    tick(0, 0, 0, 0);
    summary();
  end

endmodule